// File: doc/BRIEF.md
# Bus Ownership Sequencer

This block lets an expansion card take over a legacy PC expansion bus for a single transfer. A local client starts a transfer with a one-cycle request that gives the address, the direction, the space (memory or I/O), the width and any write data. The sequencer then raises a DMA request line and waits for the system board to return the matching active-low acknowledge. It then pulls the active-low master line. After the fixed settling delays it drives the address, the data and one command strobe. It honours the target's channel-ready wait states, releases the bus in stages, and reports completion with a one-cycle pulse.

A 16-bit transfer runs as one wide command when the target signals that it can take 16 bits. Otherwise it is split into two byte commands on the low data lane. The second command goes to the next address and moves the upper byte on bits 7:0. All timing counts clock edges of the bus clock, which is also the block's clock.

Top module: `busOwnerSeq`

## Requirements
- R1: While reset is held and in the idle state, the block releases the bus: `drqOut`=0, `masterN`=1, `addrOe`=0, `dataOe`=0, all four command strobes =1, `hiByteEnN`=1 and `done`=0.
- R2: A `reqValid` seen in idle raises `drqOut` in the next cycle. `drqOut` stays high and `masterN` stays high for as long as `dackN` is sampled high.
- R3: In the cycle after `dackN` is sampled low, `masterN` goes low while `drqOut` stays high and address and command stay off.
- R4: One cycle after `masterN` goes low, `addrOe` goes high with `busAddr` equal to the requested address. For writes `dataOe` goes high with the write data. No command is active yet.
- R5: Two cycles after `masterN` goes low, exactly one active-low strobe goes low. That strobe is `memRdN` (memory read), `memWrN` (memory write), `ioRdN` (I/O read) or `ioWrN` (I/O write).
- R6: A command lasts at least one cycle. It ends only after a clock edge at which `chanReady` is sampled high, and every edge that samples it low adds one cycle.
- R7: The release is staged one cycle apart. First the command goes high. In the next cycle `addrOe` and `dataOe` drop. In the cycle after that `masterN` goes high, `drqOut` falls, and `done` pulses for exactly one cycle.
- R8: A narrow read captures `busDataIn[7:0]` at the edge that ends the command. At `done`, `rdData` holds that byte in bits 7:0 and zero in bits 15:8.
- R9: A wide transfer whose target holds `cs16N` low at the end of the command uses one command. `hiByteEnN` is low from the address phase through the end of the command, and a read returns all 16 bits of `busDataIn`.
- R10: A wide transfer whose target has `cs16N` high at the end of the first command runs a second command. The second command is at `busAddr`+1 with `hiByteEnN` high, and the write data's upper byte is on bits 7:0. Its read byte from bits 7:0 lands in `rdData[15:8]`.
- R11: `reqValid` has no effect while a transfer is in progress. The latched address is kept, and the block returns to idle after `done`.
- R12: Asserting `rst` at any point returns the block to idle with the bus released as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Asynchronous reset, active high |
| reqValid | input | 1 | One-cycle transfer start from the local client |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqWide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| reqAddr | input | ADDR_W | Transfer address |
| reqWdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Read result, valid with `done` |
| drqOut | output | 1 | DMA request used to ask for the bus |
| dackN | input | 1 | Active-low acknowledge from the system board |
| masterN | output | 1 | Active-low bus master claim |
| addrOe | output | 1 | Address (and byte-high enable) output enable |
| busAddr | output | ADDR_W | Bus address |
| hiByteEnN | output | 1 | Active-low high-byte lane enable |
| dataOe | output | 1 | Data output enable (writes) |
| busDataOut | output | DATA_W | Write data driven to the bus |
| busDataIn | input | DATA_W | Data sampled from the bus |
| memRdN | output | 1 | Active-low memory read strobe |
| memWrN | output | 1 | Active-low memory write strobe |
| ioRdN | output | 1 | Active-low I/O read strobe |
| ioWrN | output | 1 | Active-low I/O write strobe |
| chanReady | input | 1 | Target ready; low inserts wait states |
| cs16N | input | 1 | Active-low target 16-bit capable |

## Verification
The bench varies the acknowledge latency and the number of wait states in each command. A sequencer that counts delays from the request, not from the master line, would put the address or the command out at the wrong cycle. A sequencer that ignores `chanReady` would cut the command short. The bench also drives a wide transfer to a byte-only target and checks the second command's address, lane and byte placement, which catches an off-by-one address or swapped read bytes. It checks the staged release order, a start request sent while the block is busy, and a reset during a stretched command, which must release every line at once.

// File: rtl/busOwnPkg.sv
package busOwnPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_GRANT,
    S_ADDR,
    S_CMD,
    S_WAIT,
    S_RELCMD,
    S_RELBUS
  } ownState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;      // latch a new transfer
    logic capLow;    // low lane into rdData[lo]
    logic capHigh;   // low lane into rdData[hi]
    logic capFull;   // whole bus into rdData
    logic nextHalf;  // move to second byte command
  } dpStrobe_t;

endpackage

// File: rtl/busOwnData.sv
module busOwnData
  import busOwnPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              xferWrite,
  output logic              xferIo,
  output logic              xferWide,
  output logic              secondHalf,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic              writeQ, ioQ, wideQ, secondQ;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      writeQ  <= 1'b0;
      ioQ     <= 1'b0;
      wideQ   <= 1'b0;
      secondQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ   <= reqAddr;
      wdataQ  <= reqWdata;
      writeQ  <= reqWrite;
      ioQ     <= reqIo;
      wideQ   <= reqWide;
      secondQ <= 1'b0;
    end else if (strobe.nextHalf) begin
      secondQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rdQ <= '0;
    end else if (strobe.load) begin
      rdQ <= '0;
    end else if (strobe.capFull) begin
      rdQ <= busDataIn;
    end else if (strobe.capLow) begin
      rdQ[LANE_W-1:0] <= busDataIn[LANE_W-1:0];
    end else if (strobe.capHigh) begin
      rdQ[DATA_W-1:LANE_W] <= busDataIn[LANE_W-1:0];
    end
  end

  // second byte command targets the next address, upper byte on low lane
  assign busAddr    = addrQ + ADDR_W'(secondQ);
  assign busDataOut = {wdataQ[DATA_W-1:LANE_W],
                       secondQ ? wdataQ[DATA_W-1:LANE_W] : wdataQ[LANE_W-1:0]};
  assign rdData     = rdQ;
  assign xferWrite  = writeQ;
  assign xferIo     = ioQ;
  assign xferWide   = wideQ;
  assign secondHalf = secondQ;

endmodule

// File: rtl/busOwnCtrl.sv
module busOwnCtrl
  import busOwnPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      dackN,
  input  logic      chanReady,
  input  logic      cs16N,
  input  logic      xferWrite,
  input  logic      xferIo,
  input  logic      xferWide,
  input  logic      secondHalf,
  output dpStrobe_t strobe,
  output logic      drqOut,
  output logic      masterN,
  output logic      addrOe,
  output logic      dataOe,
  output logic      hiByteEnN,
  output logic      memRdN,
  output logic      memWrN,
  output logic      ioRdN,
  output logic      ioWrN,
  output logic      done
);

  ownState_t state, nextState;
  logic      doneQ;
  logic      cmdOn;
  logic      busOwned;
  logic      addrPhase;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= (state == S_RELBUS);
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          nextState   = S_REQ;
        end
      end
      S_REQ:   if (!dackN) nextState = S_GRANT;
      S_GRANT: nextState = S_ADDR;
      S_ADDR:  nextState = S_CMD;
      S_CMD, S_WAIT: begin
        if (!chanReady) begin
          nextState = S_WAIT;
        end else if (xferWide && !secondHalf && cs16N) begin
          strobe.capLow   = 1'b1;
          strobe.nextHalf = 1'b1;
          nextState       = S_ADDR;
        end else begin
          if (xferWide && !secondHalf) strobe.capFull = 1'b1;
          else if (secondHalf)         strobe.capHigh = 1'b1;
          else                         strobe.capLow  = 1'b1;
          nextState = S_RELCMD;
        end
      end
      S_RELCMD: nextState = S_RELBUS;
      S_RELBUS: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  assign busOwned  = (state != S_IDLE) && (state != S_REQ);
  assign addrPhase = (state == S_ADDR) || (state == S_CMD) ||
                     (state == S_WAIT) || (state == S_RELCMD);
  assign cmdOn     = (state == S_CMD) || (state == S_WAIT);

  assign drqOut    = (state != S_IDLE);
  assign masterN   = !busOwned;
  assign addrOe    = addrPhase;
  assign dataOe    = addrPhase && xferWrite;
  assign hiByteEnN = !(addrPhase && xferWide && !secondHalf);
  assign memRdN    = !(cmdOn && !xferIo && !xferWrite);
  assign memWrN    = !(cmdOn && !xferIo &&  xferWrite);
  assign ioRdN     = !(cmdOn &&  xferIo && !xferWrite);
  assign ioWrN     = !(cmdOn &&  xferIo &&  xferWrite);
  assign done      = doneQ;

endmodule

// File: rtl/busOwnerSeq.sv
module busOwnerSeq
  import busOwnPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              drqOut,
  input  logic              dackN,
  output logic              masterN,
  output logic              addrOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              hiByteEnN,
  output logic              dataOe,
  output logic [DATA_W-1:0] busDataOut,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  input  logic              chanReady,
  input  logic              cs16N
);

  dpStrobe_t strobe;
  logic      xferWrite, xferIo, xferWide, secondHalf;

  busOwnCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .dackN     (dackN),
    .chanReady (chanReady),
    .cs16N     (cs16N),
    .xferWrite (xferWrite),
    .xferIo    (xferIo),
    .xferWide  (xferWide),
    .secondHalf(secondHalf),
    .strobe    (strobe),
    .drqOut    (drqOut),
    .masterN   (masterN),
    .addrOe    (addrOe),
    .dataOe    (dataOe),
    .hiByteEnN (hiByteEnN),
    .memRdN    (memRdN),
    .memWrN    (memWrN),
    .ioRdN     (ioRdN),
    .ioWrN     (ioWrN),
    .done      (done)
  );

  busOwnData #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqIo     (reqIo),
    .reqWide   (reqWide),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busDataIn (busDataIn),
    .xferWrite (xferWrite),
    .xferIo    (xferIo),
    .xferWide  (xferWide),
    .secondHalf(secondHalf),
    .busAddr   (busAddr),
    .busDataOut(busDataOut),
    .rdData    (rdData)
  );

endmodule

// File: rtl/busOwnerSeqChk.sv
module busOwnerSeqChk (
  input logic clk,
  input logic rst,
  input logic drqOut,
  input logic dackN,
  input logic masterN,
  input logic addrOe,
  input logic dataOe,
  input logic memRdN,
  input logic memWrN,
  input logic ioRdN,
  input logic ioWrN,
  input logic chanReady,
  input logic done
);

  logic cmdActive;
  assign cmdActive = !(memRdN && memWrN && ioRdN && ioWrN);

  AST_RESET_RELEASE: assert property (@(posedge clk)
    rst |=> (!drqOut && masterN && !addrOe && !dataOe && !cmdActive && !done)); // R12

  AST_DRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (drqOut && masterN && dackN) |=> drqOut); // R2

  AST_ADDR_AFTER_MASTER: assert property (@(posedge clk) disable iff (rst)
    $rose(addrOe) |-> ($past(masterN) == 1'b0)); // R4

  AST_CMD_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(cmdActive) |-> ($past(masterN) == 1'b0 && $past(masterN, 2) == 1'b0)); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({!memRdN, !memWrN, !ioRdN, !ioWrN}) <= 1); // R5

  AST_CMD_OWNS_BUS: assert property (@(posedge clk) disable iff (rst)
    cmdActive |-> (!masterN && addrOe && drqOut)); // R5

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst)
    (cmdActive && !chanReady) |=> cmdActive); // R6

  AST_CMD_OFF_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(addrOe) |-> (!cmdActive && $past(!cmdActive))); // R7

  AST_MASTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(masterN) |-> (!addrOe && $past(!addrOe) && !drqOut)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

endmodule

bind busOwnerSeq busOwnerSeqChk u_chk (
  .clk      (clk),
  .rst      (rst),
  .drqOut   (drqOut),
  .dackN    (dackN),
  .masterN  (masterN),
  .addrOe   (addrOe),
  .dataOe   (dataOe),
  .memRdN   (memRdN),
  .memWrN   (memWrN),
  .ioRdN    (ioRdN),
  .ioWrN    (ioWrN),
  .chanReady(chanReady),
  .done     (done)
);

// File: tb/sim_busOwnerSeq.sv
`timescale 1ns/1ps
module sim_busOwnerSeq;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqWrite, reqIo, reqWide;
  logic [23:0] reqAddr;
  logic [15:0] reqWdata;
  logic        done;
  logic [15:0] rdData;
  logic        drqOut, dackN, masterN, addrOe, hiByteEnN, dataOe;
  logic [23:0] busAddr;
  logic [15:0] busDataOut, busDataIn;
  logic        memRdN, memWrN, ioRdN, ioWrN, chanReady, cs16N;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;
  bit  curWrite, curIo;

  always #5 clk = ~clk;

  busOwnerSeq u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqIo(reqIo),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqWdata(reqWdata), .done(done),
    .rdData(rdData), .drqOut(drqOut), .dackN(dackN), .masterN(masterN),
    .addrOe(addrOe), .busAddr(busAddr), .hiByteEnN(hiByteEnN), .dataOe(dataOe),
    .busDataOut(busDataOut), .busDataIn(busDataIn), .memRdN(memRdN),
    .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN), .chanReady(chanReady),
    .cs16N(cs16N)
  );

  // expected vector: {drq, masterN, addrOe, dataOe, memRdN, memWrN, ioRdN, ioWrN, hiEnN, done}
  function automatic logic [9:0] mk(bit drq, bit mN, bit aOe, bit dOe, bit cmdOn,
                                    bit hiLow, bit dn);
    mk = {drq, mN, aOe, dOe,
          !(cmdOn && !curIo && !curWrite), !(cmdOn && !curIo && curWrite),
          !(cmdOn && curIo && !curWrite),  !(cmdOn && curIo && curWrite),
          !hiLow, dn};
  endfunction

  task automatic chkOut(input logic [9:0] expBits, input logic [23:0] expAddr,
                        input logic [15:0] expData, input string tag);
    logic [9:0] act;
    bit bad;
    act = {drqOut, masterN, addrOe, dataOe, memRdN, memWrN, ioRdN, ioWrN, hiByteEnN, done};
    bad = (act !== expBits) || (expBits[7] && busAddr !== expAddr) ||
          (expBits[6] && busDataOut !== expData);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s t=%0t act=%b/%h/%h exp=%b/%h/%h", tag, $time,
               act, busAddr, busDataOut, expBits, expAddr, expData);
    end
  endtask

  task automatic chkVal(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rdData act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one full transfer, stepping and comparing every cycle
  task automatic runTxn(input bit wr, input bit io, input bit wide, input logic [23:0] addr,
                        input logic [15:0] wdata, input logic [15:0] rdIn,
                        input int dackDelay, input int wait0, input int wait1,
                        input bit cap16, input bit poke);
    int nHalf;
    logic [15:0] hData;
    logic [15:0] expRd;
    curWrite = wr;
    curIo    = io;
    nHalf    = (wide && !cap16) ? 2 : 1;
    @(negedge clk);
    chkOut(mk(0, 1, 0, 0, 0, 0, 0), '0, '0, "R1");
    reqValid = 1'b1; reqWrite = wr; reqIo = io; reqWide = wide;
    reqAddr = addr; reqWdata = wdata;
    @(negedge clk);
    for (int i = 0; i <= dackDelay; i++) begin
      chkOut(mk(1, 1, 0, 0, 0, 0, 0), '0, '0, "R2");
      if (poke && i == 0) begin
        reqValid = 1'b1;        // R11: must be ignored
        reqAddr  = ~addr;
        reqWrite = !wr;
      end else begin
        reqValid = 1'b0;
      end
      if (i == dackDelay) dackN = 1'b0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chkOut(mk(1, 0, 0, 0, 0, 0, 0), '0, '0, "R3");
    @(negedge clk);
    hData = wdata;
    for (int h = 0; h < nHalf; h++) begin
      int wt;
      hData = (h == 0) ? wdata : {wdata[15:8], wdata[15:8]};
      chkOut(mk(1, 0, 1, wr, 0, wide && h == 0, 0), addr + 24'(h), hData,
             (h == 0) ? "R4" : "R10");
      cs16N     = !cap16;
      busDataIn = (h == 0) ? rdIn : {8'h5A, rdIn[15:8]};
      wt = (h == 0) ? wait0 : wait1;
      @(negedge clk);
      for (int j = 0; j <= wt; j++) begin
        chkOut(mk(1, 0, 1, wr, 1, wide && h == 0, 0), addr + 24'(h), hData,
               (j == 0) ? "R5" : "R6");
        chanReady = (j == wt);
        @(negedge clk);
      end
    end
    chkOut(mk(1, 0, 1, wr, 0, wide && nHalf == 1, 0), addr + 24'(nHalf - 1), hData, "R7");
    chanReady = 1'b1;
    @(negedge clk);
    chkOut(mk(1, 0, 0, 0, 0, 0, 0), '0, '0, "R7");
    @(negedge clk);
    chkOut(mk(0, 1, 0, 0, 0, 0, 1), '0, '0, "R7");
    if (!wr) begin
      expRd = wide ? rdIn : {8'h00, rdIn[7:0]};
      chkVal(rdData, expRd, !wide ? "R8" : (cap16 ? "R9" : "R10"));
    end
    dackN = 1'b1;
    @(negedge clk);
    chkOut(mk(0, 1, 0, 0, 0, 0, 0), '0, '0, poke ? "R11" : "R7");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqWrite = 1'b0; reqIo = 1'b0; reqWide = 1'b0;
    reqAddr = '0; reqWdata = '0; dackN = 1'b1; chanReady = 1'b1; cs16N = 1'b1;
    busDataIn = '0; curWrite = 1'b0; curIo = 1'b0;
    repeat (3) @(negedge clk);
    chkOut(mk(0, 1, 0, 0, 0, 0, 0), '0, '0, "R1");
    rst = 1'b0;

    runTxn(0, 0, 0, 24'h0C_1234, 16'h0000, 16'hBEA7, 0, 0, 0, 1, 0); // R8 narrow mem read
    runTxn(1, 0, 0, 24'h00_0451, 16'h00C3, 16'h0000, 3, 2, 0, 1, 0); // mem write, waits
    runTxn(0, 1, 1, 24'h00_0300, 16'h0000, 16'h1E2D, 1, 1, 0, 1, 0); // R9 io read wide
    runTxn(1, 1, 1, 24'h00_0310, 16'hA55A, 16'h0000, 0, 1, 0, 0, 0); // R10 io write split
    runTxn(0, 0, 1, 24'h0F_FFFE, 16'h0000, 16'h6C93, 2, 0, 3, 0, 1); // R10 + R11

    // R12: reset during a stretched command
    curWrite = 1'b1; curIo = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqIo = 1'b0; reqWide = 1'b0;
    reqAddr = 24'h12_3456; reqWdata = 16'h0077; dackN = 1'b0;
    @(negedge clk);
    reqValid = 1'b0; chanReady = 1'b0;
    repeat (4) @(negedge clk);
    chkOut(mk(1, 0, 1, 1, 1, 0, 0), 24'h12_3456, 16'h0077, "R6");
    rst = 1'b1;
    @(negedge clk);
    chkOut(mk(0, 1, 0, 0, 0, 0, 0), '0, '0, "R12");
    rst = 1'b0; dackN = 1'b1; chanReady = 1'b1;
    @(negedge clk);
    chkOut(mk(0, 1, 0, 0, 0, 0, 0), '0, '0, "R12");

    runTxn(1, 0, 1, 24'h0A_0000, 16'h3CF0, 16'h0000, 2, 0, 0, 1, 0); // R9 wide mem write

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule